// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing and Occupancy Flags

The block buffers 18-bit words between two free-running clocks, which may be unrelated or the same clock. Words enter on the rising write-clock edge when the write enable is high. They leave on the rising read-clock edge when the read enable is high. Depth is a parameter (512, 1024, 2048 or 4096 words). Each pointer crosses into the opposite domain as Gray code through a two-flop synchronizer. Every flag is computed in the domain of the port that uses it.

A mode pin is captured during reset and held until the next reset. In standard timing a word reaches `dout` only through an explicit read. In fall-through timing the head word is shown on `dout` without a read, and a read consumes the shown word. The two fixed flags change meaning with the mode. Programmable almost-empty and almost-full thresholds are written through the write port while `ld` is held high.

Named states:
- Load sequencer (write domain): `LD_AE` and `LD_AF`.
  - A write in `LD_AE` with `ld` high stores the almost-empty offset and moves to `LD_AF`.
  - A write in `LD_AF` with `ld` high stores the almost-full offset and moves back to `LD_AE`.
  - Whenever `ld` is low the sequencer returns to `LD_AE`.
- Output stage (read domain): `OUT_VACANT` and `OUT_LOADED`.
  - In fall-through timing, `OUT_VACANT` goes to `OUT_LOADED` when a word is fetched.
  - `OUT_LOADED` stays put while it is refilled by a read that finds a further word.
  - `OUT_LOADED` goes back to `OUT_VACANT` on a read that finds memory empty.
  - In standard timing the output stage stays in `OUT_VACANT`.

Top module: `dm_fifo`

## Requirements
- R1: While `rst_n` is low and after its release, both pointers are zero and both offsets are 127. In standard timing `ef_or`=1, `ff_ir`=0, `pae`=1, `paf`=0, `hf`=0 and `dout_valid`=0. In fall-through timing `ef_or`=0 and `ff_ir`=1.
- R2: `fwft_sel` is sampled only while `rst_n` is low (1 = fall-through, 0 = standard). Changing it after reset has no effect on timing or flag meaning.
- R3: In standard timing a stored word reaches `dout` only on a read-clock edge with `ren`=1 and memory non-empty. On the read-clock cycle after such a read, `dout_valid` equals `oe`; in every other cycle it is 0.
- R4: In fall-through timing a word written into an empty FIFO appears on `dout` with `ef_or`=1 after the third rising read-clock edge that follows its write edge, with no `ren`. A shown word stays on `dout` until it is read.
- R5: All flags are active high. In standard timing `ef_or` means empty and `ff_ir` means full. In fall-through timing `ef_or` means a word is shown on `dout` and `ff_ir` means a write will be accepted.
- R6: While `ld`=1, each write edge with `wen`=1 stores `din` into an offset register instead of the FIFO. The first such write loads the almost-empty offset and the second loads the almost-full offset. A third write wraps back to the almost-empty offset. Dropping `ld` restarts the sequence at the almost-empty offset.
- R7: A write while full is ignored: no pointer moves and no word is stored. Full means the write-side count equals the depth.
- R8: A read in standard timing while empty, or in fall-through timing while `ef_or`=0, is ignored. `dout` does not change.
- R9: `oe`=0 forces `dout_valid` to 0 without changing `dout` or the pointers.
- R10: `pae`=1 when the read-side count is at most the almost-empty offset. In fall-through timing that count includes a shown word. `paf`=1 when the write-side count is at least the depth minus the almost-full offset.
- R11: `hf`=1 when the write-side count is greater than half the depth.
- R12: Words leave in the order they were accepted, none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| fwft_sel | input | 1 | Timing mode, captured during reset (1 = fall-through) |
| wen | input | 1 | Write enable |
| ld | input | 1 | Offset-load select for writes |
| din | input | 18 | Write data or offset value |
| ren | input | 1 | Read enable |
| oe | input | 1 | Output valid gate |
| dout | output | 18 | Read data register |
| dout_valid | output | 1 | Read data valid, gated by `oe` |
| ef_or | output | 1 | Empty (standard) or output ready (fall-through) |
| ff_ir | output | 1 | Full (standard) or input ready (fall-through) |
| pae | output | 1 | Programmable almost-empty |
| paf | output | 1 | Programmable almost-full |
| hf | output | 1 | Half-full |

## Verification
A corrupted pointer or synchronizer shows up as a wrong word on `dout` at the very next read, or as a missing or extra word once the FIFO is drained. The bench compares every read-clock cycle against a queue, so such a fault is flagged within one read cycle. A wrong offset register or load state shows as `pae` or `paf` switching one or more words away from the expected count once the flags have settled. A fault in the output stage shows as `ef_or` rising on the wrong read edge after a write into an empty FIFO, or as a shown word changing without a read.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    typedef enum logic {LD_AE = 1'b0, LD_AF = 1'b1} ld_state_t;
    typedef enum logic {OUT_VACANT = 1'b0, OUT_LOADED = 1'b1} out_state_t;
    localparam int OFFSET_DEFAULT = 127;
endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl
    import dmf_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 18,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    input  logic [PW-1:0]     rgray_s,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [PW-1:0]     wgray,
    output logic [AW-1:0]     ae_off,
    output logic              ff_ir,
    output logic              paf,
    output logic              hf
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    ld_state_t     ld_st, ld_nx;
    logic          fwft_q;
    logic [PW-1:0] wr_bin, wr_bin_nx, wcount;
    logic [AW-1:0] af_off;
    logic          full, push;

    assign wcount    = wr_bin - g2b(rgray_s);
    assign full      = (wcount == DEPTH_P);
    assign push      = wen && !ld && !full;
    assign wr_bin_nx = wr_bin + PW'(1);

    always_comb begin
        ld_nx = ld_st;
        if (!ld) begin
            ld_nx = LD_AE;
        end else if (wen) begin
            unique case (ld_st)
                LD_AE: ld_nx = LD_AF;
                LD_AF: ld_nx = LD_AE;
            endcase
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) ld_st <= LD_AE;
        else        ld_st <= ld_nx;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            fwft_q <= fwft_sel;
            wr_bin <= '0;
            wgray  <= '0;
            ae_off <= AW'(OFFSET_DEFAULT);
            af_off <= AW'(OFFSET_DEFAULT);
        end else begin
            if (push) begin
                wr_bin <= wr_bin_nx;
                wgray  <= wr_bin_nx ^ (wr_bin_nx >> 1);
            end
            if (ld && wen) begin
                unique case (ld_st)
                    LD_AE: ae_off <= din[AW-1:0];
                    LD_AF: af_off <= din[AW-1:0];
                endcase
            end
        end
    end

    assign mem_we    = push;
    assign mem_waddr = wr_bin[AW-1:0];
    assign ff_ir     = fwft_q ? !full : full;
    assign paf       = (wcount >= (DEPTH_P - {1'b0, af_off}));
    assign hf        = (wcount > HALF_P);

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        wcount <= DEPTH_P); // R7
    AST_FULL_HOLDS_PTR: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && wen && !ld) |=> $stable(wr_bin)); // R7
    AST_LOAD_NO_PUSH: assert property (@(posedge wclk) disable iff (!rst_n)
        (ld && wen) |=> $stable(wr_bin)); // R6
endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl
    import dmf_pkg::*;
#(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 18,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              ren,
    input  logic              oe,
    input  logic [PW-1:0]     wgray_s,
    input  logic [AW-1:0]     ae_off_s,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [AW-1:0]     mem_raddr,
    output logic [PW-1:0]     rgray,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              ef_or,
    output logic              pae
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    out_state_t        out_st, out_nx;
    logic              fwft_q, vld_q, take, mem_empty, shown;
    logic [PW-1:0]     rd_bin, rd_bin_nx, count_r, occ;
    logic [DATA_W-1:0] dout_q;

    assign count_r   = g2b(wgray_s) - rd_bin;
    assign mem_empty = (count_r == '0);
    assign rd_bin_nx = rd_bin + PW'(1);
    assign shown     = (out_st == OUT_LOADED);

    always_comb begin
        out_nx = out_st;
        take   = 1'b0;
        if (!fwft_q) begin
            take   = ren && !mem_empty;
            out_nx = OUT_VACANT;
        end else begin
            unique case (out_st)
                OUT_VACANT: begin
                    take = !mem_empty;
                    if (take) out_nx = OUT_LOADED;
                end
                OUT_LOADED: begin
                    take = ren && !mem_empty;
                    if (ren && mem_empty) out_nx = OUT_VACANT;
                end
            endcase
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) out_st <= OUT_VACANT;
        else        out_st <= out_nx;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            fwft_q <= fwft_sel;
            rd_bin <= '0;
            rgray  <= '0;
            dout_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= take && !fwft_q;
            if (take) begin
                rd_bin <= rd_bin_nx;
                rgray  <= rd_bin_nx ^ (rd_bin_nx >> 1);
                dout_q <= mem_rdata;
            end
        end
    end

    assign occ        = count_r + PW'(fwft_q && shown);
    assign mem_raddr  = rd_bin[AW-1:0];
    assign dout       = dout_q;
    assign dout_valid = oe && (fwft_q ? shown : vld_q);
    assign ef_or      = fwft_q ? shown : mem_empty;
    assign pae        = (occ <= {1'b0, ae_off_s});

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        count_r <= DEPTH_P); // R12
    AST_EMPTY_HOLDS_OUT: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fwft_q && mem_empty && ren) |=> $stable(dout_q)); // R8
    AST_SHOWN_WORD_HELD: assert property (@(posedge rclk) disable iff (!rst_n)
        (fwft_q && shown && !ren) |=> (out_st == OUT_LOADED && $stable(dout_q))); // R4
endmodule

// File: rtl/dm_fifo.sv
module dm_fifo #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 18,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              wen,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    input  logic              ren,
    input  logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              ef_or,
    output logic              ff_ir,
    output logic              pae,
    output logic              paf,
    output logic              hf
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, mem_raddr, ae_off, ae_off_s;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic [DATA_W-1:0] mem_rdata;

    always_ff @(posedge wclk) begin
        if (mem_we) mem[mem_waddr] <= din;
    end
    assign mem_rdata = mem[mem_raddr];

    dmf_wr_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wen(wen), .ld(ld),
        .din(din), .rgray_s(rgray_s), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .wgray(wgray), .ae_off(ae_off), .ff_ir(ff_ir), .paf(paf), .hf(hf)
    );

    dmf_sync #(.W(PW)) u_sync_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    dmf_sync #(.W(PW)) u_sync_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));
    dmf_sync #(.W(AW)) u_sync_ae  (.clk(rclk), .rst_n(rst_n), .d(ae_off), .q(ae_off_s));

    dmf_rd_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ren(ren), .oe(oe),
        .wgray_s(wgray_s), .ae_off_s(ae_off_s), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rgray(rgray), .dout(dout),
        .dout_valid(dout_valid), .ef_or(ef_or), .pae(pae)
    );
endmodule

// File: tb/dm_fifo_tb_top.sv
`timescale 1ns/100ps
module dm_fifo_tb_top;
    localparam int DEPTH = 512;

    logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, fwft_sel = 1'b0;
    logic        wen = 1'b0, ld = 1'b0, ren = 1'b0, oe = 1'b1;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        dout_valid, ef_or, ff_ir, pae, paf, hf;

    int          n_chk = 0, n_fail = 0;
    bit          mode_fw = 1'b0, rd_pend = 1'b0;
    logic [17:0] q[$];
    logic [17:0] exp_d = '0;

    dm_fifo #(.DEPTH(DEPTH), .DATA_W(18)) dut_i (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .wen(wen), .ld(ld), .din(din), .ren(ren), .oe(oe), .dout(dout),
        .dout_valid(dout_valid), .ef_or(ef_or), .ff_ir(ff_ir),
        .pae(pae), .paf(paf), .hf(hf)
    );

    always #2 wclk = ~wclk;
    initial begin
        #0.5;
        forever #3.5 rclk = ~rclk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Reference model: accept/consume decided from port flags before each edge
    always @(posedge wclk) begin
        if (rst_n && wen && !ld && !(mode_fw ? !ff_ir : ff_ir)) q.push_back(din);
    end

    always @(posedge rclk) begin
        rd_pend = 1'b0;
        if (rst_n) begin
            if (!mode_fw && ren && !ef_or) begin
                if (q.size() == 0) chk(0, "R12 read beyond accepted words", 1, 0);
                else begin exp_d = q.pop_front(); rd_pend = 1'b1; end
            end else if (mode_fw && ren && ef_or) begin
                if (q.size() == 0) chk(0, "R12 shown word without write", 1, 0);
                else void'(q.pop_front());
            end
        end
    end

    always @(negedge rclk) begin
        if (rst_n) begin
            if (!mode_fw) begin
                if (rd_pend) begin
                    chk(dout == exp_d, "R12 read data order", dout, exp_d);
                    chk(dout_valid == oe, "R3 valid after read", dout_valid, oe);
                end else begin
                    chk(dout_valid == 1'b0, "R3 valid without read", dout_valid, 0);
                end
            end else if (ef_or) begin
                chk(q.size() > 0 && dout == q[0], "R12 shown word", dout,
                    q.size() > 0 ? q[0] : 0);
                chk(dout_valid == oe, "R9 shown valid", dout_valid, oe);
            end
        end
    end

    task automatic do_reset(input bit fw);
        rst_n = 1'b0; fwft_sel = fw; mode_fw = fw;
        wen = 0; ld = 0; ren = 0;
        q.delete();
        repeat (3) @(negedge wclk);
        rst_n = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic put_n(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk); wen = 1; din = 18'(base + i * 37);
        end
        @(negedge wclk); wen = 0;
    endtask

    task automatic read1();
        @(negedge rclk); ren = 1;
        @(negedge rclk); ren = 0;
    endtask

    task automatic drain_std();
        @(negedge rclk); ren = 1;
        while (!ef_or) @(negedge rclk);
        ren = 0;
    endtask

    initial begin
        #700000;
        chk(0, "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        // ---------- standard timing ----------
        do_reset(0);
        settle();
        chk(ef_or == 1, "R1 ef_or reset", ef_or, 1);
        chk(ff_ir == 0, "R1 ff_ir reset", ff_ir, 0);
        chk(pae == 1, "R1 pae reset", pae, 1);
        chk(paf == 0, "R1 paf reset", paf, 0);
        chk(hf == 0, "R1 hf reset", hf, 0);
        chk(dout_valid == 0, "R1 valid reset", dout_valid, 0);

        fwft_sel = 1;                      // R2: no effect after reset
        put_n(1, 18'h1234);
        settle();
        chk(ef_or == 0, "R2 R5 standard flag meaning kept", ef_or, 0);
        chk(dout == 0, "R3 no data without ren", dout, 0);
        read1();
        settle();
        chk(dout == 18'h1234, "R3 data after read", dout, 18'h1234);
        chk(ef_or == 1, "R5 empty after read", ef_or, 1);
        read1();                           // R8 read while empty
        settle();
        chk(dout == 18'h1234, "R8 empty read ignored", dout, 18'h1234);

        oe = 0;
        put_n(1, 18'h0abc);
        settle();
        @(negedge rclk); ren = 1;
        @(negedge rclk); ren = 0;
        chk(dout == 18'h0abc && dout_valid == 0, "R9 oe gates valid", dout_valid, 0);
        oe = 1;
        settle();

        put_n(127, 100);
        settle();
        chk(pae == 1, "R10 pae at 127", pae, 1);
        put_n(1, 900);
        settle();
        chk(pae == 0, "R10 pae at 128", pae, 0);
        put_n(128, 1000);
        settle();
        chk(hf == 0, "R11 hf at 256", hf, 0);
        put_n(1, 2000);
        settle();
        chk(hf == 1, "R11 hf at 257", hf, 1);
        put_n(127, 3000);
        settle();
        chk(paf == 0, "R10 paf at 384", paf, 0);
        put_n(1, 4000);
        settle();
        chk(paf == 1, "R10 paf at 385", paf, 1);
        put_n(127, 5000);
        settle();
        chk(ff_ir == 1, "R7 full at depth", ff_ir, 1);
        put_n(1, 18'h3ffff);               // R7 ignored write
        settle();
        chk(ff_ir == 1 && q.size() == DEPTH, "R7 full write ignored", q.size(), DEPTH);
        drain_std();
        settle();
        chk(ef_or == 1 && q.size() == 0, "R7 R12 drained exactly", q.size(), 0);

        // R6: offsets 9 -> ae, 500 -> af, 10 wraps to ae
        ld = 1;
        put_n(1, 9); put_n(1, 500); put_n(1, 10);
        ld = 0;
        settle();
        chk(ef_or == 1, "R6 load writes not stored", ef_or, 1);
        put_n(10, 6000);
        settle();
        chk(pae == 1, "R6 wrapped ae offset at 10", pae, 1);
        put_n(1, 7000);
        settle();
        chk(pae == 0, "R6 wrapped ae offset at 11", pae, 0);
        chk(paf == 0, "R10 loaded af offset at 11", paf, 0);
        put_n(1, 7100);
        settle();
        chk(paf == 1, "R10 loaded af offset at 12", paf, 1);
        drain_std();
        settle();

        // ---------- fall-through timing ----------
        do_reset(1);
        settle();
        chk(ef_or == 0, "R1 R5 not ready after reset", ef_or, 0);
        chk(ff_ir == 1, "R1 R5 input ready after reset", ff_ir, 1);
        chk(dout_valid == 0, "R1 valid reset fwft", dout_valid, 0);
        @(negedge wclk); wen = 1; din = 18'h15555;
        @(posedge wclk); #1 wen = 0;
        for (int e = 1; e <= 3; e++) begin
            @(posedge rclk); #0.2;
            if (e < 3) chk(ef_or == 0, "R4 not yet shown", ef_or, 0);
            else chk(ef_or == 1 && dout == 18'h15555, "R4 shown on third edge", dout, 18'h15555);
        end
        settle();
        chk(dout == 18'h15555, "R4 shown word held", dout, 18'h15555);
        put_n(4, 8000);
        settle();
        chk(pae == 1, "R10 pae counts shown word", pae, 1);
        @(negedge rclk); ren = 1;
        repeat (20) @(negedge rclk);
        ren = 0;
        settle();
        chk(ef_or == 0 && q.size() == 0, "R12 fwft drained", q.size(), 0);
        read1();                           // R8 read while not ready
        settle();
        chk(ef_or == 0 && dout == 18'(8000 + 3 * 37), "R8 not-ready read ignored",
            dout, 18'(8000 + 3 * 37));
        chk(ff_ir == 1, "R5 input ready when empty", ff_ir, 1);
        finish_run();
    end
endmodule